// File: doc/BRIEF.md
# Phase-Delayed Clock Pair Generator

This block runs on a fast source clock and builds a divided reference clock from it, using a divide ratio supplied on an input. From that reference it makes two derived clocks of the same frequency: an output clock and a sample clock. Each derived clock is moved later in phase by a whole number of fast-clock cycles. The number of cycles comes from its own 4-bit field in a 32-bit phase word. A delay of zero does not mean "no shift". It selects the inverted reference, which is a half-period (180-degree) offset.

Delay and ratio changes are taken up only at the start of a reference period, so a derived clock never sees a partial update. A requested delay that is not shorter than the period is pulled back to one cycle less than the ratio. The block also reports the phase granularity in degrees for the active ratio, so that software converting an angle into a cycle count has the step size at hand.

Top module: `phase_clk_gen`

## Requirements
- R1: The effective ratio N is `ratio_in`, or 2 when `ratio_in` is below 2. `ratio_in` is sampled while reset is held and on the clock edge that starts each new reference period. `ref_clk` repeats every N cycles and is high for the first floor(N/2) cycles of each period.
- R2: When the active delay d (taken from the low 2 bits of a field) is 1 to 3, the derived clock equals `ref_clk` delayed by exactly d fast-clock cycles.
- R3: When the active delay is 0, the derived clock is the logical inverse of `ref_clk` in every cycle.
- R4: A field written on any edge becomes the active delay only on the next edge that starts a reference period. A write on that same edge does not take effect until the period after it.
- R5: If the field's delay is greater than or equal to N, the active delay loaded is N-1.
- R6: `phase_word` holds the output-clock field in bits 11:8 and the sample-clock field in bits 23:20, and every other bit is zero. A write (`wr_en`=1) replaces all four bits of the field chosen by `wr_sel` (0 = output clock, 1 = sample clock) with `wr_val`.
- R7: `step_deg` equals 360/N rounded to the nearest integer, with halves rounded up, for the active ratio N.
- R8: While synchronous reset is held, `phase_word` is 0, `ref_clk` is 1, and both derived clocks are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast source clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ratio_in | input | RW (5) | Module divide ratio |
| wr_en | input | 1 | Field write strobe |
| wr_sel | input | 1 | Field select: 0 output clock, 1 sample clock |
| wr_val | input | FW (4) | Value written into the selected field |
| phase_word | output | AW (32) | Phase word holding both fields |
| ref_clk | output | 1 | Divided reference clock |
| out_clk | output | 1 | Phase-delayed output clock |
| smp_clk | output | 1 | Phase-delayed sample clock |
| step_deg | output | 9 | Phase step in degrees for the active ratio |

## Verification
The hardest case to reach is a field write that lands on the exact edge where a period begins, together with a ratio change at that same boundary that makes the stored delay too large. The stimulus steps through ratios 0 to 9 and through all sixteen field values. Between the writes to the two fields it inserts a varying gap, so that over the sweep the writes fall at every position within the period, including the boundary edge. Every cycle is compared against an arithmetic model of the counter, the delay history and the boundary loading rule.

// File: rtl/phase_clk_pkg.sv
// Shared types and arithmetic for the phase-delayed clock pair generator.
// Assumes divide ratios of at least 2 reach round_step.
package phase_clk_pkg;

    // Selects which delay field a write updates.
    typedef enum logic {
        FIELD_OUT = 1'b0,
        FIELD_SMP = 1'b1
    } field_sel_e;

    // Degrees per fast-clock step: 360/n rounded half up, by restoring division.
    function automatic logic [8:0] round_step(input logic [7:0] n);
        logic [9:0] num;
        logic [9:0] rem;
        logic [9:0] quo;
        num = 10'd360 + {3'b000, n[7:1]};
        rem = '0;
        quo = '0;
        for (int i = 9; i >= 0; i--) begin
            rem = {rem[8:0], num[i]};
            if (rem >= {2'b00, n}) begin
                rem    = rem - {2'b00, n};
                quo[i] = 1'b1;
            end
        end
        return 9'(quo);
    endfunction

endpackage

// File: rtl/pdc_ref_div.sv
// Reference divider: counts fast-clock cycles modulo the active ratio and
// produces the divided reference, its next value and a short history of it.
// Assumes HD >= 1. The ratio input is clamped to a minimum of 2 and is
// reloaded only at period boundaries and during reset.
module pdc_ref_div #(
    parameter int RW = 5,
    parameter int HD = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ratio_in,
    output logic [RW-1:0] ratio_q,
    output logic [RW-1:0] ratio_nxt,
    output logic          wrap,
    output logic          at_start,
    output logic          div_q,
    output logic          div_nxt,
    output logic [HD-1:0] hist_q
);
    localparam logic [RW-1:0] MIN_RATIO = RW'(2);

    logic [RW-1:0] cnt_q;
    logic [RW-1:0] cnt_nxt;
    logic [RW-1:0] ratio_eff;

    // Clamp the requested ratio to the smallest usable divide.
    always_comb ratio_eff = (ratio_in < MIN_RATIO) ? MIN_RATIO : ratio_in;

    // Next-state logic for counter, ratio and reference level.
    always_comb begin
        wrap      = (cnt_q == ratio_q - RW'(1));
        ratio_nxt = wrap ? ratio_eff : ratio_q;
        cnt_nxt   = wrap ? '0 : cnt_q + RW'(1);
        div_nxt   = (cnt_nxt < (ratio_nxt >> 1));
        at_start  = (cnt_q == '0);
    end

    // Register counter, active ratio and reference clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            ratio_q <= ratio_eff;
            div_q   <= 1'b1;
        end else begin
            cnt_q   <= cnt_nxt;
            ratio_q <= ratio_nxt;
            div_q   <= div_nxt;
        end
    end

    // History of past reference levels, one stage per cycle of delay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else begin
            hist_q[0] <= div_q;
            for (int k = 1; k < HD; k++) begin
                hist_q[k] <= hist_q[k-1];
            end
        end
    end

    // R1
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < ratio_q);

    // R1
    ratio_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !at_start |-> $stable(ratio_q));

    // R1
    ratio_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_q >= MIN_RATIO);

endmodule

// File: rtl/pdc_field_reg.sv
// Phase word holding two 4-bit delay fields at fixed bit offsets.
// A write replaces the whole field chosen by the select input. Only the
// low DW bits of each field are passed on as delays.
// Assumes the two fields do not overlap and both fit in AW bits.
module pdc_field_reg
    import phase_clk_pkg::*;
#(
    parameter int AW      = 32,
    parameter int FW      = 4,
    parameter int DW      = 2,
    parameter int OUT_LSB = 8,
    parameter int SMP_LSB = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  field_sel_e    wr_sel,
    input  logic [FW-1:0] wr_val,
    output logic [DW-1:0] dly_out,
    output logic [DW-1:0] dly_smp,
    output logic [AW-1:0] word
);
    logic [FW-1:0] fld_out_q;
    logic [FW-1:0] fld_smp_q;

    // Replace the selected field on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_out_q <= '0;
            fld_smp_q <= '0;
        end else if (wr_en) begin
            if (wr_sel == FIELD_OUT) fld_out_q <= wr_val;
            else                     fld_smp_q <= wr_val;
        end
    end

    // Assemble the phase word; all bits outside the fields read zero.
    always_comb begin
        word                   = '0;
        word[OUT_LSB +: FW]    = fld_out_q;
        word[SMP_LSB +: FW]    = fld_smp_q;
    end

    // Expose the delay bits of each field.
    always_comb begin
        dly_out = word[OUT_LSB +: DW];
        dly_smp = word[SMP_LSB +: DW];
    end

    // R6
    fld_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == FIELD_OUT) |=> (word[OUT_LSB +: FW] == $past(wr_val)));

    // R6
    fld_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(word));

endmodule

// File: rtl/pdc_tap.sv
// One phase-delayed clock: loads its delay from a field at each period start,
// clamps it below the ratio, and picks the matching tap of the reference
// history. Tap 0 is the inverted reference; tap k (k >= 1) is the reference
// k cycles late. Assumes the taps are supplied as next-cycle values.
module pdc_tap #(
    parameter int RW = 5,
    parameter int DW = 2,
    localparam int MAX_D = (1 << DW) - 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [DW-1:0]  dly_field,
    input  logic           wrap,
    input  logic           at_start,
    input  logic [RW-1:0]  ratio_nxt,
    input  logic [RW-1:0]  ratio_q,
    input  logic           div_q,
    input  logic [MAX_D:0] taps,
    output logic           clk_o
);
    logic [RW-1:0] lim;
    logic [DW-1:0] dly_clamp;
    logic [DW-1:0] act_q;
    logic [DW-1:0] act_nxt;

    // Clamp the requested delay to one cycle less than the coming ratio.
    always_comb begin
        lim       = ratio_nxt - RW'(1);
        dly_clamp = (RW'(dly_field) > lim) ? lim[DW-1:0] : dly_field;
        act_nxt   = wrap ? dly_clamp : act_q;
    end

    // Hold the active delay and register the selected tap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_q <= '0;
            clk_o <= 1'b0;
        end else begin
            act_q <= act_nxt;
            clk_o <= taps[act_nxt];
        end
    end

    // R4
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !at_start |-> $stable(act_q));

    // R5
    act_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        RW'(act_q) < ratio_q);

    // R3
    invert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == '0) |-> (clk_o != div_q));

    // R2
    one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (act_q == DW'(1)) |-> (clk_o == $past(div_q)));

endmodule

// File: rtl/phase_clk_gen.sv
// Top of the phase-delayed clock pair generator. Instantiates the reference
// divider, the phase word and one tap per derived clock, and reports the
// phase step for the active ratio. Assumes DW >= 2 and RW <= 8.
module phase_clk_gen
    import phase_clk_pkg::*;
#(
    parameter int RW      = 5,
    parameter int FW      = 4,
    parameter int DW      = 2,
    parameter int AW      = 32,
    parameter int OUT_LSB = 8,
    parameter int SMP_LSB = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [RW-1:0] ratio_in,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [FW-1:0] wr_val,
    output logic [AW-1:0] phase_word,
    output logic          ref_clk,
    output logic          out_clk,
    output logic          smp_clk,
    output logic [8:0]    step_deg
);
    localparam int MAX_D = (1 << DW) - 1;
    localparam int HD    = MAX_D - 1;
    localparam int NCLK  = 2;

    logic [RW-1:0]  ratio_q;
    logic [RW-1:0]  ratio_nxt;
    logic           wrap;
    logic           at_start;
    logic           div_q;
    logic           div_nxt;
    logic [HD-1:0]  hist_q;
    logic [MAX_D:0] taps;
    logic [DW-1:0]  dly [NCLK];
    logic [NCLK-1:0] clk_pair;

    pdc_ref_div #(.RW(RW), .HD(HD)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ratio_in  (ratio_in),
        .ratio_q   (ratio_q),
        .ratio_nxt (ratio_nxt),
        .wrap      (wrap),
        .at_start  (at_start),
        .div_q     (div_q),
        .div_nxt   (div_nxt),
        .hist_q    (hist_q)
    );

    pdc_field_reg #(
        .AW(AW), .FW(FW), .DW(DW), .OUT_LSB(OUT_LSB), .SMP_LSB(SMP_LSB)
    ) u_fields (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (field_sel_e'(wr_sel)),
        .wr_val  (wr_val),
        .dly_out (dly[0]),
        .dly_smp (dly[1]),
        .word    (phase_word)
    );

    // Tap vector: inverted next reference, current reference, then history.
    always_comb begin
        taps[0] = ~div_nxt;
        taps[1] = div_q;
    end

    for (genvar k = 2; k <= MAX_D; k++) begin : g_hist_tap
        assign taps[k] = hist_q[k-2];
    end

    for (genvar g = 0; g < NCLK; g++) begin : g_tap
        pdc_tap #(.RW(RW), .DW(DW)) u_tap (
            .clk       (clk),
            .rst_n     (rst_n),
            .dly_field (dly[g]),
            .wrap      (wrap),
            .at_start  (at_start),
            .ratio_nxt (ratio_nxt),
            .ratio_q   (ratio_q),
            .div_q     (div_q),
            .taps      (taps),
            .clk_o     (clk_pair[g])
        );
    end

    // Drive the clock outputs and the phase step for the active ratio.
    always_comb begin
        ref_clk  = div_q;
        out_clk  = clk_pair[0];
        smp_clk  = clk_pair[1];
        step_deg = round_step(8'(ratio_q));
    end

    logic [15:0] step_prod;
    logic [15:0] step_bound;
    always_comb begin
        step_prod  = 16'(step_deg) * 16'(ratio_q);
        step_bound = 16'd360 + 16'(ratio_q >> 1);
    end

    // R7
    step_round_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_prod <= step_bound) && (step_prod + 16'(ratio_q) > step_bound));

endmodule

// File: tb/phase_clk_gen_test.sv
module phase_clk_gen_test;
    localparam int RW = 5;
    localparam int FW = 4;
    localparam int AW = 32;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [RW-1:0] ratio_in = RW'(4);
    logic          wr_en = 1'b0;
    logic          wr_sel = 1'b0;
    logic [FW-1:0] wr_val = '0;
    logic [AW-1:0] phase_word;
    logic          ref_clk, out_clk, smp_clk;
    logic [8:0]    step_deg;

    always #10 clk = ~clk;

    phase_clk_gen uut (
        .clk(clk), .rst_n(rst_n), .ratio_in(ratio_in), .wr_en(wr_en),
        .wr_sel(wr_sel), .wr_val(wr_val), .phase_word(phase_word),
        .ref_clk(ref_clk), .out_clk(out_clk), .smp_clk(smp_clk),
        .step_deg(step_deg)
    );

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;

    // Arithmetic model state
    int m_ratio, m_cnt, nr;
    int m_f [2];
    int m_a [2];
    int dh [4];

    function automatic int eff(input int r);
        return (r < 2) ? 2 : r;
    endfunction

    function automatic int clampd(input int d, input int n);
        return (d >= n) ? n - 1 : d;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ratio = eff(int'(ratio_in));
            m_cnt = 0;
            m_f[0] = 0; m_f[1] = 0; m_a[0] = 0; m_a[1] = 0;
            dh[0] = 1; dh[1] = 0; dh[2] = 0; dh[3] = 0;
        end else begin
            if (m_cnt == m_ratio - 1) begin
                nr = eff(int'(ratio_in));
                m_a[0] = clampd(m_f[0] & 3, nr);
                m_a[1] = clampd(m_f[1] & 3, nr);
                m_cnt = 0;
                m_ratio = nr;
            end else begin
                m_cnt = m_cnt + 1;
            end
            if (wr_en) m_f[int'(wr_sel)] = int'(wr_val);
            dh[3] = dh[2]; dh[2] = dh[1]; dh[1] = dh[0];
            dh[0] = (m_cnt < m_ratio / 2) ? 1 : 0;
        end
    end

    task automatic chk(input string tag, input int got, input int exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, got, exp, cyc);
        end
    endtask

    task automatic chk_tap(input int g, input int got);
        int raw, cl, exp;
        string tag;
        raw = m_f[g] & 3;
        cl = clampd(raw, m_ratio);
        exp = (m_a[g] == 0) ? (1 - dh[0]) : dh[m_a[g]];
        if (m_a[g] != cl)          tag = "R4 pending delay";
        else if (raw >= m_ratio)   tag = "R5 clamped delay";
        else if (m_a[g] == 0)      tag = "R3 inverted";
        else                       tag = "R2 delayed";
        chk($sformatf("%s clk%0d", tag, g), got, exp);
    endtask

    task automatic check_all();
        chk("R1 reference", int'(ref_clk), dh[0]);
        chk_tap(0, int'(out_clk));
        chk_tap(1, int'(smp_clk));
        chk("R6 phase word", int'(phase_word), (m_f[0] << 8) | (m_f[1] << 20));
        chk("R7 step", int'(step_deg), (360 + m_ratio / 2) / m_ratio);
    endtask

    task automatic cyc_step(input bit we, input bit sel, input int val);
        @(negedge clk);
        if (!done) check_all();
        wr_en = we;
        wr_sel = sel;
        wr_val = FW'(val);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !done) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk("R8 reset word", int'(phase_word), 0);
        chk("R8 reset ref", int'(ref_clk), 1);
        chk("R8 reset out", int'(out_clk), 0);
        chk("R8 reset smp", int'(smp_clk), 0);
        chk("R7 reset step", int'(step_deg), 90);
        rst_n = 1'b1;
        repeat (6) cyc_step(0, 0, 0);
        for (int r = 0; r < 10; r++) begin
            ratio_in = RW'(r);
            for (int d = 0; d < 16; d++) begin
                cyc_step(1, 0, d);
                repeat (d % 3) cyc_step(0, 0, 0);
                cyc_step(1, 1, 15 - d);
                repeat (2 * eff(r) + 3 + (d % 2)) cyc_step(0, 0, 0);
            end
        end
        // Return to long ratio with fixed delays for a final settle
        ratio_in = RW'(7);
        cyc_step(1, 0, 3);
        cyc_step(1, 1, 2);
        repeat (30) cyc_step(0, 0, 0);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule